// File: doc/BRIEF.md
# Oscillator Fail Flag and Output Control

This block lives in the fast system-clock domain of a real-time-clock core. It watches a slow oscillator signal that has already been synchronized into that domain, and it keeps a sticky fail flag. Software reads this flag as bit 7 of the minutes register. The flag tells software that the timekeeping may be invalid. Any of these events raises it: the oscillator goes quiet for too long, the stop bit halts the oscillator, or the supply monitor reports low voltage. Power-on reset also leaves the flag raised.

Software can lower the flag by writing 0 to bit 7 of register address 1. The write takes effect only after the oscillator has run without a break for a minimum number of its own rising edges. Loss of the oscillator, an active stop bit or a low-supply condition restarts that run count. The same block holds the control register at address 7. Bit 7 of the control register decides whether the open-drain output pin is pulled low or released. Bit 6 of the control register always reads as 0.

Top module: `oscfail_guard`

## Requirements
- R1: After reset the fail flag is 1, the control register reads 0x80, and `out_pull_low` is 0.
- R2: A stop bit that is high at a rising clock edge sets the fail flag at that edge.
- R3: A low-supply input that is high at a rising clock edge sets the fail flag at that edge.
- R4: The oscillator is declared lost when `LOSS_LIMIT` system clocks pass with no rising edge of `osc_sync`. Loss sets the fail flag on the next clock edge. Gaps shorter than this limit leave the flag alone.
- R5: Once the fail flag is set, it stays at 1 until it is cleared by a write of 0. It holds through any number of idle cycles, even after every set cause has gone away.
- R6: A write to address 1 with data bit 7 equal to 0 clears the fail flag, provided at least `RUN_EDGES` oscillator rising edges have been seen since the last restart of the run count.
- R7: A clearing write that arrives before the run count is complete has no effect, and the flag stays 1. Loss, stop bit and low supply each restart the run count from zero.
- R8: A write to address 1 with data bit 7 equal to 1 sets the fail flag.
- R9: A write to address 7 loads the control register. Bit 6 is always stored as 0, and every other bit is stored as written.
- R10: `out_pull_low` is 1 exactly when control bit 7 is 0.
- R11: A write to any address other than 1 and 7 changes neither the fail flag nor the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| osc_sync | input | 1 | Oscillator level, synchronized to clk |
| stop_bit | input | 1 | Oscillator stop request |
| low_supply | input | 1 | Supply monitor reports voltage too low to oscillate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address of the write |
| wr_data | input | 8 | Write data |
| fail_flag | output | 1 | Sticky oscillator-fail flag |
| ctrl_reg | output | 8 | Control register contents |
| out_pull_low | output | 1 | Enable for the open-drain low driver |

## Verification
The hardest case to reach is a clearing write that lands after the oscillator has restarted but before the run count is complete. To get there, the bench stops its oscillator model long enough for loss to be declared. It then restarts the oscillator and issues the clear after only a couple of oscillator edges. It then waits well past `RUN_EDGES` edges and repeats the clear to show that the gate opens. A single-cycle stop pulse followed at once by a clear shows that the stop bit also restarts the count. The loss threshold is probed from both sides: shortly after the oscillator halts, and again after the limit has passed.

// File: rtl/oscfail_guard.sv
module oscfail_guard #(
  parameter int LOSS_LIMIT = 16,
  parameter int RUN_EDGES  = 8,
  localparam int GW = $clog2(LOSS_LIMIT + 1),
  localparam int RW = $clog2(RUN_EDGES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_sync,
  input  logic       stop_bit,
  input  logic       low_supply,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       fail_flag,
  output logic [7:0] ctrl_reg,
  output logic       out_pull_low
);
  localparam logic [2:0] MIN_ADDR  = 3'd1;
  localparam logic [2:0] CTRL_ADDR = 3'd7;

  logic          osc_q;
  logic [GW-1:0] gap_q;
  logic [RW-1:0] run_q;

  wire osc_rise = osc_sync & ~osc_q;
  wire lost     = (gap_q == GW'(LOSS_LIMIT));
  wire restart  = lost | stop_bit | low_supply;
  wire run_ok   = (run_q == RW'(RUN_EDGES));
  wire min_wr   = wr_en && (wr_addr == MIN_ADDR);
  wire ctrl_wr  = wr_en && (wr_addr == CTRL_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_q <= 1'b0;
      gap_q <= '0;
    end else begin
      osc_q <= osc_sync;
      if (osc_rise)   gap_q <= '0;
      else if (!lost) gap_q <= gap_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  run_q <= '0;
    else if (restart)            run_q <= '0;
    else if (osc_rise && !run_ok) run_q <= run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          fail_flag <= 1'b1;
    else if (restart)                    fail_flag <= 1'b1;
    else if (min_wr && wr_data[7])       fail_flag <= 1'b1;
    else if (min_wr && run_ok)           fail_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_reg <= 8'h80;
    else if (ctrl_wr) ctrl_reg <= {wr_data[7], 1'b0, wr_data[5:0]};
  end

  assign out_pull_low = ~ctrl_reg[7];
endmodule

// File: rtl/oscfail_guard_chk.sv
module oscfail_guard_chk #(
  parameter int LOSS_LIMIT = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       osc_sync,
  input logic       stop_bit,
  input logic       low_supply,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       fail_flag,
  input logic [7:0] ctrl_reg,
  input logic       out_pull_low
);
  logic     ck_prev;
  int unsigned ck_gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_prev <= 1'b0;
      ck_gap  <= 0;
    end else begin
      ck_prev <= osc_sync;
      if (osc_sync && !ck_prev)            ck_gap <= 0;
      else if (ck_gap < LOSS_LIMIT)        ck_gap <= ck_gap + 1;
    end
  end

  a_r2_stop_sets: assert property (@(posedge clk) disable iff (!rst_n)
    stop_bit |=> fail_flag);

  a_r3_low_sets: assert property (@(posedge clk) disable iff (!rst_n)
    low_supply |=> fail_flag);

  a_r4_loss_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_gap >= LOSS_LIMIT) |=> fail_flag);

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_flag && !(wr_en && wr_addr == 3'd1 && !wr_data[7])) |=> fail_flag);

  a_r9_bit6_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd7) |=> (ctrl_reg[6] == 1'b0 && ctrl_reg[7] == $past(wr_data[7])));

  a_r10_pin_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_reg[7]) |-> out_pull_low);

  a_r11_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == 3'd7) |=> $stable(ctrl_reg));
endmodule

bind oscfail_guard oscfail_guard_chk #(.LOSS_LIMIT(LOSS_LIMIT)) chk_i (
  .clk(clk), .rst_n(rst_n), .osc_sync(osc_sync), .stop_bit(stop_bit),
  .low_supply(low_supply), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .fail_flag(fail_flag), .ctrl_reg(ctrl_reg), .out_pull_low(out_pull_low)
);

// File: tb/oscfail_guard_tb_top.sv
`timescale 1ns/1ps
module oscfail_guard_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_sync = 1'b0;
  logic       stop_bit = 1'b0;
  logic       low_supply = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       fail_flag;
  logic [7:0] ctrl_reg;
  logic       out_pull_low;
  logic       osc_en = 1'b1;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  oscfail_guard #(.LOSS_LIMIT(16), .RUN_EDGES(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .osc_sync(osc_sync), .stop_bit(stop_bit),
    .low_supply(low_supply), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fail_flag(fail_flag), .ctrl_reg(ctrl_reg), .out_pull_low(out_pull_low)
  );

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      if (osc_en) begin
        if (ph == 2) begin osc_sync = ~osc_sync; ph = 0; end
        else ph++;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    idle(3);
    chk("R1 flag", fail_flag, 1);
    chk("R1 ctrl", ctrl_reg, 8'h80);
    chk("R1 pin", out_pull_low, 0);
    rst_n = 1'b1;
    idle(2);
    chk("R1 flag after release", fail_flag, 1);
  endtask

  task automatic t_early_clear;
    wr(3'd1, 8'h00);
    chk("R7 early clear ignored", fail_flag, 1);
  endtask

  task automatic t_clear;
    idle(100);
    wr(3'd1, 8'h00);
    chk("R6 clear after run", fail_flag, 0);
    idle(40);
    chk("R5 stays clear while running", fail_flag, 0);
  endtask

  task automatic t_loss;
    osc_en = 1'b0;
    idle(5);
    chk("R4 short gap no loss", fail_flag, 0);
    idle(25);
    chk("R4 loss sets flag", fail_flag, 1);
    osc_en = 1'b1;
    idle(15);
    wr(3'd1, 8'h00);
    chk("R7 loss restarts run count", fail_flag, 1);
    idle(100);
    wr(3'd1, 8'h00);
    chk("R6 clear after recovery", fail_flag, 0);
  endtask

  task automatic t_stop;
    @(negedge clk); stop_bit = 1'b1;
    @(negedge clk); stop_bit = 1'b0;
    chk("R2 stop sets flag", fail_flag, 1);
    wr(3'd1, 8'h00);
    chk("R7 stop restarts run count", fail_flag, 1);
    idle(100);
    wr(3'd1, 8'h00);
    chk("R6 clear after stop", fail_flag, 0);
  endtask

  task automatic t_low;
    @(negedge clk); low_supply = 1'b1;
    @(negedge clk); low_supply = 1'b0;
    chk("R3 low supply sets flag", fail_flag, 1);
    idle(150);
    chk("R5 sticky without write", fail_flag, 1);
    wr(3'd1, 8'h00);
    chk("R6 clear after low supply", fail_flag, 0);
    wr(3'd1, 8'h80);
    chk("R8 write one sets flag", fail_flag, 1);
    wr(3'd1, 8'h7F);
    chk("R6 clear with other bits set", fail_flag, 0);
  endtask

  task automatic t_ctrl;
    wr(3'd7, 8'h7F);
    chk("R9 ctrl bit6 forced low", ctrl_reg, 8'h3F);
    chk("R10 pin pulled low", out_pull_low, 1);
    wr(3'd7, 8'hC5);
    chk("R9 ctrl load", ctrl_reg, 8'h85);
    chk("R10 pin released", out_pull_low, 0);
    wr(3'd2, 8'h00);
    chk("R11 other address ctrl", ctrl_reg, 8'h85);
    chk("R11 other address flag", fail_flag, 0);
    wr(3'd0, 8'h80);
    chk("R11 addr0 bit7 flag", fail_flag, 0);
  endtask

  initial begin
    t_reset();
    t_early_clear();
    t_clear();
    t_loss();
    t_stop();
    t_low();
    t_ctrl();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule